// File: doc/BRIEF.md
# I2C Status and Control Register Target

This block is an I2C target that exposes a small bank of byte-wide registers to a board controller. It answers a single fixed 7-bit device address. In a write, the master first sends the register index and may then send data bytes for that index. To read, the master writes the index, issues a repeated START with the read bit set, and clocks out the selected register.

The bank holds two read-only revision constants and the live status of a power sequencer: the group-enable vector, sixteen power-good bits and an active-low fault flag. It also holds one writable control byte. Bit 0 of that byte drives an external supply enable for a USB port, and it is off after reset. SCL and SDA are oversampled by the system clock through a two-flop synchronizer. The SDA pin is only ever pulled low or released. Multi-master arbitration and clock stretching are not supported.

Top module: `i2c_stat_regbank`

## Requirements
- R1: The target pulls SDA low in the acknowledge slot only when the 7-bit address equals 0x55 (read/write flag in bit 0 of the address byte, 0 = write). On any other address it leaves SDA released until the next START.
- R2: In a write transaction, the first byte after the address sets the register index. Every later byte in the same transaction is written to that same index.
- R3: Index 0x00 reads the firmware revision, 0x03 by default. Index 0x01 reads the board revision, 0x02 by default. Writes change neither.
- R4: Index 0x06 reads the power-group enable vector in bits 6:0, with bit 7 always 0.
- R5: Index 0x08 reads power-good bits 7:0 and index 0x09 reads power-good bits 15:8. With all rails good, both read 0xFF.
- R6: Index 0x0A reads the active-low sequencer fault flag in bit 0 with bits 7:1 at 0. It reads 0x01 when there is no fault.
- R7: Index 0x0E is a read/write byte that resets to 0x00. Its bit 0 drives `usb_en_o`, and the enable changes only as a result of a write to that index.
- R8: Writes to read-only or unmapped indices are acknowledged and change nothing. Reads of unmapped indices return 0x00.
- R9: A read returns the register at the most recently written index (0x00 after reset). Every further byte in the same read repeats that register, and SDA is released after the master's NACK.
- R10: SCL and SDA pass through two synchronizing flops before START, STOP or edges are detected. SDA is driven only low. After reset and after any STOP, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| grp_en_i | input | NGRP (7) | Power-group enable status |
| pg_i | input | NPG (16) | Power-good status bits |
| seq_fault_n_i | input | 1 | Sequencer fault flag, active low |
| usb_en_o | output | 1 | USB supply enable, bit 0 of the control byte |

## Verification
The bench builds the block with its default parameters: address 0x55, seven group-enable bits, sixteen power-good bits and a two-stage synchronizer. It drives SCL with a half period of eight system clocks. That is only a few cycles more than the synchronizer-plus-register latency, so the acknowledge and data-bit hand-offs on SCL falling edges are exercised close to their timing margin. With sixteen power-good bits, both status bytes and their boundary between index 0x08 and 0x09 are in reach. The bench also randomizes the status inputs and control writes between transactions.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [3:0] {
    LS_IDLE,
    LS_ADDR,
    LS_AACK,
    LS_IDX,
    LS_IACK,
    LS_WDAT,
    LS_DACK,
    LS_RDAT,
    LS_RACK
  } link_st_e;

  localparam logic [7:0] IX_FW    = 8'h00;
  localparam logic [7:0] IX_BRD   = 8'h01;
  localparam logic [7:0] IX_GRP   = 8'h06;
  localparam logic [7:0] IX_PG_LO = 8'h08;
  localparam logic [7:0] IX_FLT   = 8'h0A;
  localparam logic [7:0] IX_CTRL  = 8'h0E;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/i2c_rb_link.sv
module i2c_rb_link
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       idx_we,
  output logic       dat_we,
  output logic [7:0] wr_byte
);

  link_st_e   state_q, state_n;
  logic [2:0] bitcnt_q, bitcnt_n;
  logic [6:0] rx_q, rx_n;
  logic [7:0] tx_q, tx_n;
  logic       ph_q, ph_n;
  logic       rw_q, rw_n;
  logic       nack_q, nack_n;
  logic       oe_q, oe_n;
  logic       scl_d, sda_d;

  logic       scl_rise, scl_fall, start_det, stop_det, last_bit;
  logic [7:0] rx_byte;

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign rx_byte   = {rx_q, sda_s};
  assign last_bit  = (bitcnt_q == 3'd7);
  assign wr_byte   = rx_byte;
  assign sda_oe    = oe_q;

  always_comb begin
    state_n  = state_q;
    bitcnt_n = bitcnt_q;
    rx_n     = rx_q;
    tx_n     = tx_q;
    ph_n     = ph_q;
    rw_n     = rw_q;
    nack_n   = nack_q;
    oe_n     = oe_q;
    idx_we   = 1'b0;
    dat_we   = 1'b0;

    if (start_det) begin
      state_n  = LS_ADDR;
      bitcnt_n = 3'd0;
      ph_n     = 1'b0;
      oe_n     = 1'b0;
    end else if (stop_det) begin
      state_n = LS_IDLE;
      ph_n    = 1'b0;
      oe_n    = 1'b0;
    end else begin
      unique case (state_q)
        LS_ADDR, LS_IDX, LS_WDAT: begin
          if (scl_rise) begin
            rx_n     = rx_byte[6:0];
            bitcnt_n = bitcnt_q + 3'd1;
            if (last_bit) begin
              if (state_q == LS_ADDR) begin
                if (rx_byte[7:1] == DEV_ADDR) begin
                  rw_n    = rx_byte[0];
                  state_n = LS_AACK;
                end else begin
                  state_n = LS_IDLE;
                end
              end else if (state_q == LS_IDX) begin
                idx_we  = 1'b1;
                state_n = LS_IACK;
              end else begin
                dat_we  = 1'b1;
                state_n = LS_DACK;
              end
            end
          end
        end
        LS_AACK, LS_IACK, LS_DACK: begin
          if (scl_fall && !ph_q) begin
            oe_n = 1'b1;
          end
          if (scl_rise) begin
            ph_n = 1'b1;
          end
          if (scl_fall && ph_q) begin
            ph_n = 1'b0;
            oe_n = 1'b0;
            if (state_q == LS_AACK && rw_q) begin
              tx_n    = {rd_byte[6:0], 1'b0};
              oe_n    = ~rd_byte[7];
              state_n = LS_RDAT;
            end else if (state_q == LS_AACK) begin
              state_n = LS_IDX;
            end else begin
              state_n = LS_WDAT;
            end
          end
        end
        LS_RDAT: begin
          if (scl_fall) begin
            oe_n = ~tx_q[7];
            tx_n = {tx_q[6:0], 1'b0};
          end
          if (scl_rise) begin
            bitcnt_n = bitcnt_q + 3'd1;
            if (last_bit) begin
              state_n = LS_RACK;
              ph_n    = 1'b0;
            end
          end
        end
        LS_RACK: begin
          if (scl_fall && !ph_q) begin
            oe_n = 1'b0;
          end
          if (scl_rise) begin
            ph_n   = 1'b1;
            nack_n = sda_s;
          end
          if (scl_fall && ph_q) begin
            ph_n = 1'b0;
            if (!nack_q) begin
              tx_n    = {rd_byte[6:0], 1'b0};
              oe_n    = ~rd_byte[7];
              state_n = LS_RDAT;
            end else begin
              state_n = LS_IDLE;
            end
          end
        end
        default: begin
          state_n = LS_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LS_IDLE;
      bitcnt_q <= 3'd0;
      rx_q     <= 7'd0;
      tx_q     <= 8'd0;
      ph_q     <= 1'b0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b0;
      oe_q     <= 1'b0;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      state_q  <= state_n;
      bitcnt_q <= bitcnt_n;
      rx_q     <= rx_n;
      tx_q     <= tx_n;
      ph_q     <= ph_n;
      rw_q     <= rw_n;
      nack_q   <= nack_n;
      oe_q     <= oe_n;
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
  import i2c_rb_pkg::*;
#(
  parameter logic [7:0] FW_REV  = 8'h03,
  parameter logic [7:0] BRD_REV = 8'h02,
  parameter int         NGRP    = 7,
  parameter int         NPG     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_we,
  input  logic            dat_we,
  input  logic [7:0]      wr_byte,
  input  logic [NGRP-1:0] grp_en,
  input  logic [NPG-1:0]  pg,
  input  logic            fault_n,
  output logic [7:0]      rd_byte,
  output logic            ctrl_bit0
);

  localparam int PG_BYTES = NPG / 8;

  logic [7:0] idx_q, idx_n;
  logic [7:0] ctrl_q, ctrl_n;
  logic       ctrl_en;

  assign ctrl_en = dat_we && (idx_q == IX_CTRL);

  always_comb begin
    idx_n  = idx_we  ? wr_byte : idx_q;
    ctrl_n = ctrl_en ? wr_byte : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= 8'h00;
      ctrl_q <= 8'h00;
    end else begin
      idx_q  <= idx_n;
      ctrl_q <= ctrl_n;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (idx_q == IX_FW)   rd_byte = FW_REV;
    if (idx_q == IX_BRD)  rd_byte = BRD_REV;
    if (idx_q == IX_GRP)  rd_byte = 8'(grp_en);
    if (idx_q == IX_FLT)  rd_byte = {7'd0, fault_n};
    if (idx_q == IX_CTRL) rd_byte = ctrl_q;
    for (int k = 0; k < PG_BYTES; k++) begin
      if (idx_q == IX_PG_LO + 8'(k)) rd_byte = pg[k*8 +: 8];
    end
  end

  assign ctrl_bit0 = ctrl_q[0];

endmodule

// File: rtl/i2c_stat_regbank.sv
module i2c_stat_regbank #(
  parameter logic [6:0] DEV_ADDR    = 7'h55,
  parameter logic [7:0] FW_REV      = 8'h03,
  parameter logic [7:0] BRD_REV     = 8'h02,
  parameter int         NGRP        = 7,
  parameter int         NPG         = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [NGRP-1:0] grp_en_i,
  input  logic [NPG-1:0]  pg_i,
  input  logic            seq_fault_n_i,
  output logic            usb_en_o
);

  logic [1:0] pin_s;
  logic       scl_s, sda_s;
  logic       idx_we, dat_we;
  logic [7:0] wr_byte, rd_byte;

  i2c_rb_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    (pin_s)
  );

  assign scl_s = pin_s[1];
  assign sda_s = pin_s[0];

  i2c_rb_link #(
    .DEV_ADDR(DEV_ADDR)
  ) u_link (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_s  (scl_s),
    .sda_s  (sda_s),
    .rd_byte(rd_byte),
    .sda_oe (sda_oe_o),
    .idx_we (idx_we),
    .dat_we (dat_we),
    .wr_byte(wr_byte)
  );

  i2c_rb_regs #(
    .FW_REV (FW_REV),
    .BRD_REV(BRD_REV),
    .NGRP   (NGRP),
    .NPG    (NPG)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (idx_we),
    .dat_we   (dat_we),
    .wr_byte  (wr_byte),
    .grp_en   (grp_en_i),
    .pg       (pg_i),
    .fault_n  (seq_fault_n_i),
    .rd_byte  (rd_byte),
    .ctrl_bit0(usb_en_o)
  );

endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_s,
  input logic sda_oe,
  input logic usb_en,
  input logic idx_we,
  input logic dat_we
);

  // R2: index and data strobes fire only on a synchronized SCL rising edge
  p_strobe_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we || dat_we) |-> (scl_s && !$past(scl_s)));

  // R7: the supply enable moves only after a data write strobe
  p_ctrl_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_en != $past(usb_en)) |-> $past(dat_we));

  // R10: a STOP seen on the synchronized pins releases SDA on the next cycle
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && sda_s && !$past(sda_s)) |=> !sda_oe);

  // R10: SDA is only ever pulled low while SCL is low
  p_pull_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

endmodule

bind i2c_stat_regbank i2c_rb_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .scl_s (scl_s),
  .sda_s (sda_s),
  .sda_oe(sda_oe_o),
  .usb_en(usb_en_o),
  .idx_we(idx_we),
  .dat_we(dat_we)
);

// File: tb/i2c_stat_regbank_tb.sv
module i2c_stat_regbank_tb;

  localparam int         H    = 8;
  localparam logic [6:0] ADDR = 7'h55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe, usb_en;
  logic [6:0]  grp = 7'h7F;
  logic [15:0] pg = 16'hFFFF;
  logic        flt_n = 1'b1;
  logic [7:0]  m_ctrl = 8'h00;
  wire         sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  i2c_stat_regbank u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .grp_en_i     (grp),
    .pg_i         (pg),
    .seq_fault_n_i(flt_n),
    .usb_en_o     (usb_en)
  );

  function automatic logic [7:0] exp_reg(input logic [7:0] idx);
    case (idx)
      8'h00:   return 8'h03;
      8'h01:   return 8'h02;
      8'h06:   return {1'b0, grp};
      8'h08:   return pg[7:0];
      8'h09:   return pg[15:8];
      8'h0A:   return {7'd0, flt_n};
      8'h0E:   return m_ctrl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H/2);
    b = sda_bus;  tick(H/2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] dat, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(idx, a1);
    send_byte(dat, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    logic a0, a1, a2;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(idx, a1);
    bus_start();
    send_byte({ADDR, 1'b1}, a2);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic ok, a;
    logic [7:0] idx;
    logic [7:0] pool [8];
    pool = '{8'h00, 8'h01, 8'h06, 8'h08, 8'h09, 8'h0A, 8'h0E, 8'h05};
    void'($urandom(32'h5EED_0042));

    tick(5);
    check("R7 reset usb_en", {7'd0, usb_en}, 8'h00);
    check("R10 reset sda_oe", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    tick(5);
    check("R10 idle sda_oe", {7'd0, sda_oe}, 8'h00);

    // R9: read with no index written since reset returns index 0x00
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    check("R1 address ack", {7'd0, a}, 8'h01);
    recv_byte(d, 1'b0);
    bus_stop();
    check("R9 default index read", d, 8'h03);

    reg_read(8'h00, d); check("R3 firmware revision", d, 8'h03);
    reg_read(8'h01, d); check("R3 board revision", d, 8'h02);
    reg_write(8'h00, 8'h5A, ok);
    check("R8 ro write acked", {7'd0, ok}, 8'h01);
    reg_read(8'h00, d); check("R3 firmware revision unchanged", d, 8'h03);

    // R4 group byte, bit 7 zero with all groups on
    grp = 7'h7F;
    reg_read(8'h06, d); check("R4 group enables all on", d, 8'h7F);
    grp = 7'h25;
    reg_read(8'h06, d); check("R4 group enables pattern", d, 8'h25);

    // R5 power-good bytes
    pg = 16'hFFFF;
    reg_read(8'h08, d); check("R5 pg low all good", d, 8'hFF);
    reg_read(8'h09, d); check("R5 pg high all good", d, 8'hFF);
    pg = 16'hC3A5;
    reg_read(8'h08, d); check("R5 pg low pattern", d, 8'hA5);
    reg_read(8'h09, d); check("R5 pg high pattern", d, 8'hC3);

    // R6 fault flag
    flt_n = 1'b1;
    reg_read(8'h0A, d); check("R6 no fault", d, 8'h01);
    flt_n = 1'b0;
    reg_read(8'h0A, d); check("R6 fault", d, 8'h00);
    flt_n = 1'b1;

    // R7 control byte
    reg_read(8'h0E, d); check("R7 control reset value", d, 8'h00);
    reg_write(8'h0E, 8'h01, ok); m_ctrl = 8'h01;
    check("R7 usb_en set", {7'd0, usb_en}, 8'h01);
    reg_read(8'h0E, d); check("R7 control readback", d, 8'h01);
    reg_write(8'h0E, 8'h00, ok); m_ctrl = 8'h00;
    check("R7 usb_en cleared", {7'd0, usb_en}, 8'h00);

    // R8 unmapped index
    reg_write(8'h03, 8'hFF, ok);
    check("R8 unmapped write acked", {7'd0, ok}, 8'h01);
    reg_read(8'h03, d); check("R8 unmapped read zero", d, 8'h00);
    check("R8 usb_en untouched", {7'd0, usb_en}, 8'h00);
    reg_read(8'hFF, d); check("R8 top index zero", d, 8'h00);

    // R1 foreign address: no ack, SDA released, no write lands
    bus_start();
    send_byte({7'h54, 1'b0}, a);
    check("R1 foreign address nack", {7'd0, a}, 8'h00);
    send_byte(8'h0E, a);
    check("R1 released after foreign address", {7'd0, a}, 8'h00);
    send_byte(8'h01, a);
    bus_stop();
    check("R1 foreign write ignored", {7'd0, usb_en}, 8'h00);
    bus_start();
    send_byte({7'h2A, 1'b1}, a);
    check("R1 foreign read nack", {7'd0, a}, 8'h00);
    bus_stop();

    // R2 two data bytes go to the same index
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h0E, a);
    send_byte(8'hA4, a);
    check("R2 first data ack", {7'd0, a}, 8'h01);
    send_byte(8'h3D, a);
    bus_stop();
    m_ctrl = 8'h3D;
    check("R2 last byte drives usb_en", {7'd0, usb_en}, 8'h01);
    reg_read(8'h0E, d); check("R2 last byte stored", d, 8'h3D);

    // R2/R9 index-only write then separate read transaction
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h01, a);
    bus_stop();
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(d, 1'b0);
    bus_stop();
    check("R9 read at last written index", d, 8'h02);

    // R9 repeated bytes in one read, release after NACK
    pg = 16'h96F0;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h09, a);
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(d, 1'b1); check("R9 burst byte 0", d, 8'h96);
    recv_byte(d, 1'b1); check("R9 burst byte 1", d, 8'h96);
    recv_byte(d, 1'b0); check("R9 burst byte 2", d, 8'h96);
    tick(6);
    check("R9 sda released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();
    check("R10 sda released after stop", {7'd0, sda_oe}, 8'h00);

    // random mix
    for (int it = 0; it < 24; it++) begin
      grp   = 7'($urandom);
      pg    = 16'($urandom);
      flt_n = 1'($urandom);
      idx   = pool[$urandom % 8];
      if ($urandom % 3 == 0) begin
        d = 8'($urandom);
        reg_write(idx, d, ok);
        if (idx == 8'h0E) m_ctrl = d;
        check("R8 random write acked", {7'd0, ok}, 8'h01);
        check("R7 random usb_en", {7'd0, usb_en}, {7'd0, m_ctrl[0]});
      end
      reg_read(idx, d);
      check("R5 random register read", d, exp_reg(idx));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule